// File: doc/BRIEF.md
# ECC Error Status Capture Register

This block sits in a memory controller beside the ECC checker of a 64-bit data path. It holds one status word that shows which of the eight byte lanes produced a corrected error. It also raises an interrupt request for corrected errors and drives an active-low machine-check line for uncorrectable errors.

The first corrected-error event after the register is empty is logged. Every lane strobe present in that cycle is captured together, and the word then stays frozen. Software reads the word at offset 0x98. It re-arms the register by writing all ones to that same offset. An uncorrectable-error strobe pulls the machine-check line low for a minimum number of clocks, but only while a separate machine-check enable input is high.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the status word reads 0x0000_0000, `irqCorr` is low and `mchkN` is high.
- R2: While the word is empty, a cycle in which any `laneCorr` bit is high loads every high bit at once. Bit i of the word stands for byte lane i, and a 1 means a corrected error was seen in that lane.
- R3: Once any flag is set, later lane strobes leave the word unchanged until it is cleared.
- R4: A write to offset 0x98 with data 0xFFFF_FFFF clears the word and re-arms capture. A write of any other value to that offset changes nothing.
- R5: When a clearing write and a lane strobe fall in the same cycle, the clear wins and the word reads zero. If the strobe is still present in the next cycle, it is captured then.
- R6: `irqCorr` is high exactly while at least one lane flag is set, and it goes low with the clearing write.
- R7: An uncorrectable strobe sampled with `mchkEn` high drives `mchkN` low from the next cycle for PULSE_MIN cycles (default 2).
- R8: An uncorrectable strobe sampled with `mchkEn` low does not drive `mchkN` low.
- R9: An uncorrectable strobe that arrives during a low pulse restarts the count, so `mchkN` stays low for PULSE_MIN cycles after the last strobe.
- R10: Bits 31 to 8 of the word always read zero, and a read at any address other than 0x98 returns zero.
- R11: A write of 0xFFFF_FFFF to any address other than 0x98 has no effect on the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneCorr | input | 8 | Per-lane corrected-error strobes |
| uncorrErr | input | 1 | Uncorrectable-error strobe |
| mchkEn | input | 1 | Machine-check enable |
| regAddr | input | 8 | Register address offset |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr` |
| irqCorr | output | 1 | Corrected-error interrupt request level |
| mchkN | output | 1 | Active-low machine-check output |

## Verification
The properties assume that every input is stable around the rising clock edge. They also assume that a strobe lasting several cycles is meant to count as several events. Under that assumption the machine-check restart rule and the capture-on-the-next-cycle rule can be observed directly. The stimulus changes inputs only on the falling edge and holds each strobe for whole cycles. It keeps the address at 0x98 except in the tests that deliberately probe other offsets.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  typedef struct packed {
    logic capture;
    logic clear;
  } logStrobe_t;
endpackage

// File: rtl/ecc_err_ctrl.sv
module ecc_err_ctrl
  import ecc_err_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h98,
  parameter int PULSE_MIN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  laneCorr,
  input  logic              uncorrErr,
  input  logic              mchkEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              logEmpty,
  output logStrobe_t        strobe,
  output logic              mchkN
);
  localparam int CNT_W = $clog2(PULSE_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_MIN);

  logic clearHit;
  logic [CNT_W-1:0] pulseCnt;

  // re-arm only on the exact all-ones pattern at the register offset
  assign clearHit = regWr && (regAddr == REG_OFFSET) && (regWdata == '1);

  always_comb begin
    strobe.clear   = clearHit;
    strobe.capture = logEmpty && (|laneCorr) && !clearHit;
  end

  // machine-check stretcher: every enabled event reloads the count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (uncorrErr && mchkEn) begin
      pulseCnt <= CNT_LOAD;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign mchkN = (pulseCnt == '0);
endmodule

// File: rtl/ecc_err_dp.sv
module ecc_err_dp
  import ecc_err_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h98
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobe_t        strobe,
  input  logic [LANES-1:0]  laneCorr,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqCorr,
  output logic              logEmpty,
  output logic [LANES-1:0]  flagsQ
);
  logic irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      irqQ   <= 1'b0;
    end else if (strobe.clear) begin
      flagsQ <= '0;
      irqQ   <= 1'b0;
    end else if (strobe.capture) begin
      flagsQ <= laneCorr;
      irqQ   <= 1'b1;
    end
  end

  assign logEmpty = (flagsQ == '0);
  assign irqCorr  = irqQ;
  // upper bits are reserved and read as zero
  assign rdData   = (regAddr == REG_OFFSET) ? DATA_W'(flagsQ) : '0;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h98,
  parameter int PULSE_MIN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  laneCorr,
  input  logic              uncorrErr,
  input  logic              mchkEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              irqCorr,
  output logic              mchkN
);
  logStrobe_t strobe;
  logic logEmpty;
  logic [LANES-1:0] flagsQ;

  ecc_err_ctrl #(
    .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REG_OFFSET(REG_OFFSET), .PULSE_MIN(PULSE_MIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .laneCorr(laneCorr), .uncorrErr(uncorrErr),
    .mchkEn(mchkEn), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .logEmpty(logEmpty), .strobe(strobe), .mchkN(mchkN)
  );

  ecc_err_dp #(
    .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .laneCorr(laneCorr),
    .regAddr(regAddr), .rdData(rdData), .irqCorr(irqCorr),
    .logEmpty(logEmpty), .flagsQ(flagsQ)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int LANES = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h98
) (
  input logic              clk,
  input logic              rstN,
  input logic [LANES-1:0]  laneCorr,
  input logic              uncorrErr,
  input logic              mchkEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] rdData,
  input logic              irqCorr,
  input logic              mchkN,
  input logic [LANES-1:0]  flagsQ
);
  logic wipe;
  assign wipe = regWr && (regAddr == REG_OFFSET) && (&regWdata);

  a_r2_capture_all: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ == '0 && |laneCorr && !wipe) |=> (flagsQ == $past(laneCorr)));

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ != '0 && !wipe) |=> $stable(flagsQ));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    wipe |=> (flagsQ == '0 && !irqCorr));

  a_r6_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    irqCorr == (flagsQ != '0));

  a_r7_min_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mchkN) |=> !mchkN);

  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    (uncorrErr && mchkEn) |=> !mchkN);

  a_r8_gated: assert property (@(posedge clk) disable iff (!rstN)
    (mchkN && !(uncorrErr && mchkEn)) |=> mchkN);

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:LANES] == '0);
endmodule

bind ecc_err_log ecc_err_log_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk(clk), .rstN(rstN), .laneCorr(laneCorr), .uncorrErr(uncorrErr),
  .mchkEn(mchkEn), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
  .rdData(rdData), .irqCorr(irqCorr), .mchkN(mchkN), .flagsQ(flagsQ)
);

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFF = 8'h98;

  logic clk = 1'b0;
  logic rstN;
  logic [7:0] laneCorr;
  logic uncorrErr, mchkEn, regWr;
  logic [7:0] regAddr;
  logic [31:0] regWdata, rdData;
  logic irqCorr, mchkN;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_log u0 (
    .clk(clk), .rstN(rstN), .laneCorr(laneCorr), .uncorrErr(uncorrErr),
    .mchkEn(mchkEn), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .rdData(rdData), .irqCorr(irqCorr), .mchkN(mchkN)
  );

  // {lanes[8], doWrite[1], wdata[32], expected word[8]}
  localparam logic [48:0] VEC [10] = '{
    {8'h05, 1'b0, 32'h0000_0000, 8'h05},
    {8'h80, 1'b0, 32'h0000_0000, 8'h05},
    {8'h00, 1'b1, 32'h0000_FFFF, 8'h05},
    {8'h00, 1'b1, 32'hFFFF_FFFF, 8'h00},
    {8'h3C, 1'b1, 32'hFFFF_FFFF, 8'h00},
    {8'h3C, 1'b0, 32'h0000_0000, 8'h3C},
    {8'h01, 1'b1, 32'hFFFF_FFFE, 8'h3C},
    {8'h00, 1'b1, 32'hFFFF_FFFF, 8'h00},
    {8'hFF, 1'b0, 32'h0000_0000, 8'hFF},
    {8'h00, 1'b1, 32'hFFFF_FFFF, 8'h00}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    laneCorr = '0; uncorrErr = 0; regWr = 0; regWdata = '0; regAddr = OFF;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); mchkEn = 1; rstN = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
    check("R1 word", rdData, 32'h0);
    check("R1 irq", {31'b0, irqCorr}, 32'h0);
    check("R1 mchkN", {31'b0, mchkN}, 32'h1);

    // table: R2 capture, R3 freeze, R4 exact clear, R5 clear priority, R6 irq
    for (int i = 0; i < 10; i++) begin
      laneCorr = VEC[i][48:41];
      regWr    = VEC[i][40];
      regWdata = VEC[i][39:8];
      tick();
      check($sformatf("R2 R3 R4 R5 vec%0d word", i), rdData, {24'h0, VEC[i][7:0]});
      check($sformatf("R6 vec%0d irq", i), {31'b0, irqCorr}, {31'b0, VEC[i][7:0] != 8'h0});
    end
    idle(); tick();

    // R10: reserved bits and other addresses
    laneCorr = 8'hA5; tick(); idle();
    check("R10 reserved", rdData, 32'h0000_00A5);
    regAddr = 8'h9C; #1;
    check("R10 other address read", rdData, 32'h0);
    // R11: all-ones written elsewhere is ignored
    regWr = 1; regWdata = '1; tick(); idle(); #1;
    check("R11 foreign write", rdData, 32'h0000_00A5);
    check("R11 irq kept", {31'b0, irqCorr}, 32'h1);
    regWr = 1; regWdata = '1; tick(); idle();

    // R7: single enabled strobe -> two low cycles
    uncorrErr = 1; tick(); uncorrErr = 0;
    check("R7 low cycle 1", {31'b0, mchkN}, 32'h0);
    tick();
    check("R7 low cycle 2", {31'b0, mchkN}, 32'h0);
    tick();
    check("R7 released", {31'b0, mchkN}, 32'h1);

    // R8: disabled strobe
    mchkEn = 0; uncorrErr = 1; tick(); uncorrErr = 0;
    check("R8 gated 1", {31'b0, mchkN}, 32'h1);
    tick();
    check("R8 gated 2", {31'b0, mchkN}, 32'h1);
    mchkEn = 1;

    // R9: second strobe mid-pulse restarts the count
    uncorrErr = 1; tick();
    check("R9 low a", {31'b0, mchkN}, 32'h0);
    tick(); uncorrErr = 0;
    check("R9 low b", {31'b0, mchkN}, 32'h0);
    tick();
    check("R9 low c", {31'b0, mchkN}, 32'h0);
    tick();
    check("R9 released", {31'b0, mchkN}, 32'h1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule